// File: doc/BRIEF.md
# Random-Offset Random-Width Glitch Pulse Generator

This block makes one synthetic glitch pulse in each system-clock period for which it is armed. The start time of the pulse after the system-clock edge and the length of the pulse both come from pseudo-random codes. The block runs on a fast timebase clock, and one fast tick stands for one unit delay element. The system-clock edge reaches the block as a one-tick strobe on that fast clock.

Two 3-bit LFSRs supply the codes: one sets the onset offset and the other sets the width. At each strobe, the current value of each LFSR is taken as that cycle's code, and then the LFSR steps. Each code drives a one-hot choice among eight delay taps, and tap k stands for a delay of 2+k ticks.

The onset works like a set/reset element. While the block is armed, the element sets after the chosen onset delay. The pulse is that element's output XOR-ed with a copy of it delayed by the chosen width delay. Dropping the arm input clears the element. The next strobe also clears it, and that cuts off a pulse that has not finished. A flag then reports the cut for one system cycle.

Top module: `tpulse_gen`

## Requirements
- R1: Each code register follows the sequence s -> {s[1:0], s[2]^s[1]}. This sequence has period 7 and never reaches zero. The offset LFSR is seeded from seed[2:0] and the width LFSR from seed[5:3].
- R2: While rst_n is low, each 3-bit half of seed is loaded into its LFSR. A half that is all zero is loaded as 3'b001 instead.
- R3: off_code and wid_code change only at a strobe (sys_edge high at a rising clk_fast edge). At the strobe they take the LFSR values held before it, and they hold between strobes.
- R4: In an armed cycle, pulse first goes high when the tick count since the strobe edge equals 2+off_code. The tick count is 0 right after the strobe edge.
- R5: The pulse stays high for 2+wid_code ticks, unless the next strobe cuts it short.
- R6: If arm is low at a strobe, no pulse appears in that system cycle.
- R7: If arm is low at any non-strobe edge, pulse is low from that edge on. No further pulse appears until a later strobe that finds arm high, even if arm returns high earlier.
- R8: At most one pulse appears in each system cycle.
- R9: At a strobe, trunc goes high and holds until the next strobe if the cycle that just ended was still armed and 2+off_code+2+wid_code exceeded its length in ticks. Otherwise trunc goes low. Any pulse is low right after every strobe edge.
- R10: After reset, pulse, trunc, off_code and wid_code are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast timebase clock; one tick is one unit delay |
| rst_n | input | 1 | Synchronous active-low reset; loads the seeds |
| sys_edge | input | 1 | One-tick strobe marking a system-clock edge |
| arm | input | 1 | Arm control; low clears the onset element |
| seed | input | 6 | LFSR seeds: [2:0] offset, [5:3] width |
| pulse | output | 1 | Generated glitch pulse |
| off_code | output | 3 | Onset code for the current system cycle |
| wid_code | output | 3 | Width code for the current system cycle |
| trunc | output | 1 | Previous armed cycle's pulse did not fit in it |

## Verification
The codes and trunc are registered at the strobe edge, so their new values are due in the tick that follows that edge. The pulse rises 2+off_code edges after the strobe and falls 2+wid_code edges later. It falls one edge after arm drops or after the next strobe. A behavioural model in the bench counts ticks from each strobe and derives every expected value from that count. The bench samples the outputs at the falling edge, half a tick after the edge that produced them, and compares them with the model on every tick. A separate tick counter in the checker confirms the onset tick on its own.

// File: rtl/tpulse_gen.sv
module tpulse_gen #(
  parameter int BASE_DLY = 2,
  parameter int CNT_W    = 8
) (
  input  logic       clk_fast,
  input  logic       rst_n,
  input  logic       sys_edge,
  input  logic       arm,
  input  logic [5:0] seed,
  output logic       pulse,
  output logic [2:0] off_code,
  output logic [2:0] wid_code,
  output logic       trunc
);
  localparam int LW   = 3;
  localparam int NTAP = 1 << LW;
  localparam int MAXD = BASE_DLY + NTAP - 1;

  function automatic logic [LW-1:0] lfsr_step(input logic [LW-1:0] s);
    return {s[1:0], s[2] ^ s[1]};
  endfunction

  function automatic logic [LW-1:0] no_zero(input logic [LW-1:0] s);
    return (s == '0) ? LW'(1) : s;
  endfunction

  logic [LW-1:0]    lfsr_off, lfsr_wid;
  logic [CNT_W-1:0] cnt;
  logic             cyc_armed;
  logic             onset_q;
  logic [MAXD-1:0]  dly;
  logic [NTAP-1:0]  on_sel, wid_sel, on_hit, wid_tap;
  logic             set_now, dly_q;
  logic [CNT_W:0]   fit_limit;

  assign on_sel  = NTAP'(1) << off_code;
  assign wid_sel = NTAP'(1) << wid_code;

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    assign on_hit[k]  = (cnt == CNT_W'(BASE_DLY + k - 1));
    assign wid_tap[k] = dly[BASE_DLY + k - 1];
  end

  assign set_now   = |(on_sel & on_hit);
  assign dly_q     = |(wid_sel & wid_tap);
  assign pulse     = onset_q ^ dly_q;
  assign fit_limit = (CNT_W+1)'(2*BASE_DLY - 1) + (CNT_W+1)'(off_code) + (CNT_W+1)'(wid_code);

  always_ff @(posedge clk_fast) begin
    if (!rst_n) begin
      lfsr_off  <= no_zero(seed[2:0]);
      lfsr_wid  <= no_zero(seed[5:3]);
      off_code  <= '0;
      wid_code  <= '0;
      cnt       <= '0;
      cyc_armed <= 1'b0;
      onset_q   <= 1'b0;
      dly       <= '0;
      trunc     <= 1'b0;
    end else if (sys_edge) begin
      trunc     <= cyc_armed && ({1'b0, cnt} < fit_limit);
      off_code  <= lfsr_off;
      wid_code  <= lfsr_wid;
      lfsr_off  <= lfsr_step(lfsr_off);
      lfsr_wid  <= lfsr_step(lfsr_wid);
      cnt       <= '0;
      cyc_armed <= arm;
      onset_q   <= 1'b0;
      dly       <= '0;
    end else begin
      if (cnt != '1) cnt <= cnt + 1'b1;
      if (!arm) begin
        cyc_armed <= 1'b0;
        onset_q   <= 1'b0;
        dly       <= '0;
      end else begin
        if (cyc_armed && set_now) onset_q <= 1'b1;
        dly <= {dly[MAXD-2:0], onset_q};
      end
    end
  end
endmodule

module tpulse_gen_chk #(
  parameter int BASE_DLY = 2,
  parameter int CNT_W    = 8
) (
  input logic       clk_fast,
  input logic       rst_n,
  input logic       sys_edge,
  input logic       arm,
  input logic       pulse,
  input logic [2:0] off_code,
  input logic [2:0] wid_code,
  input logic       trunc
);
  logic [CNT_W-1:0] tc;

  always_ff @(posedge clk_fast) begin
    if (!rst_n || sys_edge) tc <= '0;
    else if (tc != '1)      tc <= tc + 1'b1;
  end

  p_codes_hold_r3: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !sys_edge |=> ($stable(off_code) && $stable(wid_code)));

  p_codes_nonzero_r1: assert property (@(posedge clk_fast) disable iff (!rst_n)
    sys_edge |=> (off_code != 3'd0 && wid_code != 3'd0));

  p_unarmed_quiet_r7: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !arm |=> !pulse);

  p_edge_cuts_r9: assert property (@(posedge clk_fast) disable iff (!rst_n)
    sys_edge |=> !pulse);

  p_flag_hold_r9: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !sys_edge |=> $stable(trunc));

  p_onset_tick_r4: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $rose(pulse) |-> (tc == CNT_W'(BASE_DLY) + CNT_W'(off_code)));
endmodule

bind tpulse_gen tpulse_gen_chk #(.BASE_DLY(BASE_DLY), .CNT_W(CNT_W)) u_chk (
  .clk_fast(clk_fast), .rst_n(rst_n), .sys_edge(sys_edge), .arm(arm),
  .pulse(pulse), .off_code(off_code), .wid_code(wid_code), .trunc(trunc)
);

// File: tb/tpulse_gen_bench.sv
`timescale 1ns/1ps
module tpulse_gen_bench;
  logic       clk_fast = 1'b0;
  logic       rst_n    = 1'b0;
  logic       sys_edge = 1'b0;
  logic       arm      = 1'b0;
  logic [5:0] seed     = 6'b000000;
  logic       pulse, trunc;
  logic [2:0] off_code, wid_code;

  int n_run = 0, n_fail = 0, n_tick = 0;
  bit done = 0;
  string tag = "R10";

  int m_lo, m_lw, m_co, m_cw, m_t, m_tr;
  bit m_armed;

  always #2 clk_fast = ~clk_fast;

  tpulse_gen u_tpulse_gen (
    .clk_fast(clk_fast), .rst_n(rst_n), .sys_edge(sys_edge), .arm(arm), .seed(seed),
    .pulse(pulse), .off_code(off_code), .wid_code(wid_code), .trunc(trunc)
  );

  function automatic int nxt(input int s);
    int b2 = (s >> 2) & 1;
    int b1 = (s >> 1) & 1;
    return ((s << 1) & 6) | (b2 ^ b1);
  endfunction

  always @(posedge clk_fast) begin
    if (!rst_n) begin
      m_lo = (seed[2:0] == 0) ? 1 : int'(seed[2:0]);
      m_lw = (seed[5:3] == 0) ? 1 : int'(seed[5:3]);
      m_co = 0; m_cw = 0; m_t = 0; m_tr = 0; m_armed = 0;
    end else if (sys_edge) begin
      m_tr = (m_armed && (m_t + 1 < 4 + m_co + m_cw)) ? 1 : 0;
      m_co = m_lo; m_cw = m_lw;
      m_lo = nxt(m_lo); m_lw = nxt(m_lw);
      m_t = 0; m_armed = arm;
    end else begin
      if (!arm) m_armed = 0;
      if (m_t < 255) m_t++;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at tick %0d", what, tag, act, exp, n_tick);
    end
  endtask

  always @(negedge clk_fast) begin
    n_tick++;
    if (rst_n && !done) begin
      chk("pulse", int'(pulse),
          (m_armed && m_t >= 2 + m_co && m_t < 4 + m_co + m_cw) ? 1 : 0);
      chk("off_code R1 R3", int'(off_code), m_co);
      chk("wid_code R1 R3", int'(wid_code), m_cw);
      chk("trunc R9", int'(trunc), m_tr);
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_fast);
  endtask

  task automatic sys_cycle(input int len, input bit a);
    arm = a; sys_edge = 1'b1;
    ticks(1);
    sys_edge = 1'b0;
    ticks(len - 1);
  endtask

  task automatic do_reset(input logic [5:0] s);
    rst_n = 1'b0; seed = s; arm = 1'b0; sys_edge = 1'b0;
    ticks(3);
    rst_n = 1'b1;
    ticks(1);
    tag = "R10";
    chk("reset pulse R10", int'(pulse), 0);
    chk("reset trunc R10", int'(trunc), 0);
    chk("reset codes R10", int'({wid_code, off_code}), 0);
  endtask

  initial begin
    @(negedge clk_fast);
    do_reset(6'b110_000);
    tag = "R2";
    sys_cycle(24, 1'b1);
    chk("zero seed R2 off", int'(off_code), 1);
    chk("seed R2 wid", int'(wid_code), 6);
    tag = "R1 R3 R4 R5 R8";
    for (int c = 0; c < 10; c++) sys_cycle(24, 1'b1);
    tag = "R6";
    for (int c = 0; c < 3; c++) sys_cycle(24, 1'b0);
    tag = "R9";
    for (int c = 0; c < 9; c++) sys_cycle(9, 1'b1);
    for (int c = 0; c < 5; c++) sys_cycle(12, 1'b1);
    tag = "R7";
    for (int c = 0; c < 6; c++) begin
      arm = 1'b1; sys_edge = 1'b1; ticks(1);
      sys_edge = 1'b0; ticks(3 + c);
      arm = 1'b0; ticks(2);
      arm = 1'b1; ticks(14 - c);
    end
    sys_cycle(20, 1'b1);
    do_reset(6'b000_000);
    tag = "R2";
    sys_cycle(20, 1'b1);
    chk("zero seed R2 off", int'(off_code), 1);
    chk("zero seed R2 wid", int'(wid_code), 1);
    tag = "R1 R4 R5";
    for (int c = 0; c < 8; c++) sys_cycle(20, 1'b1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    ticks(20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog [all] actual=hung expected=finished");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule